// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block forms the address path of a synchronous burst memory. A start word address is captured on a clock edge when a burst is opened. After that, the block produces the address of each following beat of a four-beat burst. The block has two active-low load strobes. The first one, the controller strobe, loads on its own. The second one, the processor strobe, loads only while the active-low chip enable is also asserted. Once a burst is open, an active-low advance input decides on each clock whether the beat counter steps or holds.

Only the two least significant address bits change over the burst. They follow a linear order (start plus beat, modulo four) or an interleaved order (start XOR beat). A static order input selects the order, and its value is captured with each new load. The bits above the beat field come straight from the address register and never receive a carry. After the fourth beat the sequence wraps back to the start address. A burst-active flag tells the array control that a valid burst address is present. The outputs come only from registers, so every result appears in the cycle after the edge that caused it.

Top module: `burst_addr_gen`

## Requirements
- R1: When `load_ctl_n` is 0 at a rising edge, `word_addr` equals the `addr_in` value sampled at that edge from the next cycle on, as beat 0 of a new burst.
- R2: When `load_cpu_n` is 0 and `chip_en_n` is 0 at a rising edge, the block loads exactly as in R1.
- R3: When `chip_en_n` is 1, `load_cpu_n` has no effect: without a controller load and with `adv_n` at 1, `word_addr` does not change.
- R4: Inside an open burst, each rising edge with `adv_n` at 0 and no load moves to the next beat. With `adv_n` at 1 the address holds.
- R5: With the captured order equal to 1 (interleaved), the low two bits of beat k are the start bits XOR k. A start of 01 gives 01, 00, 11, 10.
- R6: With the captured order equal to 0 (linear), the low two bits of beat k are (start bits + k) mod 4. A start of 01 gives 01, 10, 11, 00.
- R7: One advance after the fourth beat, the address returns to the start address, and the sequence repeats.
- R8: Between loads, `word_addr` bits above bit 1 stay equal to the loaded value. No carry is passed up from the beat field.
- R9: Both strobes active in the same cycle count as one load. A load wins over an advance in the same cycle, so the next cycle shows beat 0.
- R10: The value of `order_ilv` is captured at each load. A change of `order_ilv` during a burst does not alter that burst's order.
- R11: After reset `word_addr` is 0 and `burst_active` is 0. Advances before the first load leave `word_addr` at 0.
- R12: `burst_active` goes to 1 in the cycle after the first load and then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_ctl_n | input | 1 | Controller load strobe, active low, not gated |
| load_cpu_n | input | 1 | Processor load strobe, active low, gated by chip enable |
| chip_en_n | input | 1 | Active-low chip enable that qualifies the processor strobe |
| adv_n | input | 1 | Active-low beat advance; 1 holds the current beat |
| order_ilv | input | 1 | Burst order: 1 interleaved, 0 linear; captured at each load |
| addr_in | input | ADDR_W | Start word address |
| word_addr | output | ADDR_W | Word address of the current beat |
| burst_active | output | 1 | High once a burst address has been loaded |

## Verification
Every result here is one register stage from its cause. A load, an advance or a hold applied before rising edge n shows on `word_addr` and `burst_active` in the cycle after edge n. The bench drives its inputs on the falling edge and updates its behavioural model on the rising edge. On the next falling edge it compares the outputs with the model, which therefore checks each beat exactly one edge after its stimulus. Fixed-value checks of the wrap, no-carry and order-capture cases are sampled at the same falling edge, counted in beats from the load.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

   // width of the burst beat field; four beats per burst
   localparam int unsigned BEAT_BITS = 2;
   localparam int unsigned BEATS     = 1 << BEAT_BITS;

   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } burst_order_e;

endpackage

// File: rtl/burst_load_ctl.sv
module burst_load_ctl (
   input  logic load_ctl_n,
   input  logic load_cpu_n,
   input  logic chip_en_n,
   output logic load
);

   logic ctl_hit;
   logic cpu_hit;

   assign ctl_hit = ~load_ctl_n;
   assign cpu_hit = ~load_cpu_n & ~chip_en_n;
   // two strobes in one cycle collapse into a single load
   assign load    = ctl_hit | cpu_hit;

   always_comb begin
      if (!load_cpu_n && !chip_en_n) begin
         a_r2_cpu_loads: assert (load === 1'b1);
      end
   end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
   parameter int unsigned CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             adv_n,
   output logic [CNT_W-1:0] beat_q,
   output logic             active_q
);

   logic             step;
   logic [CNT_W-1:0] beat_d;

   assign step   = active_q & ~adv_n & ~load;
   // natural wrap of the counter returns to beat 0 after the last beat
   assign beat_d = load ? '0 : (step ? beat_q + 1'b1 : beat_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beat_q   <= '0;
         active_q <= 1'b0;
      end else begin
         beat_q <= beat_d;
         if (load) begin
            active_q <= 1'b1;
         end
      end
   end

   a_r4_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && adv_n) |=> $stable(beat_q));

   a_r11_idle_before_load: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_q && !load) |=> (beat_q == '0));

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
   import burst_addr_pkg::*;
#(
   parameter int unsigned CNT_W       = 2,
   parameter bit          SUPPORT_ILV = 1'b1
) (
   input  logic [CNT_W-1:0] start_bits,
   input  logic [CNT_W-1:0] beat,
   input  burst_order_e     order,
   output logic [CNT_W-1:0] low_bits
);

   logic [CNT_W-1:0] lin_bits;

   assign lin_bits = start_bits + beat;

   generate
      if (SUPPORT_ILV) begin : g_both
         logic [CNT_W-1:0] ilv_bits;
         for (genvar b = 0; b < CNT_W; b++) begin : g_bit
            assign ilv_bits[b] = start_bits[b] ^ beat[b];
         end
         assign low_bits = (order == ORD_INTERLEAVE) ? ilv_bits : lin_bits;
      end else begin : g_linear_only
         logic unused_order;
         assign unused_order = order;
         assign low_bits     = lin_bits;
      end
   endgenerate

   always_comb begin
      if (beat == '0) begin
         a_r1_beat0_is_start: assert (low_bits == start_bits);
      end
   end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import burst_addr_pkg::*;
#(
   parameter int unsigned ADDR_W      = 18,
   parameter bit          SUPPORT_ILV = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_ctl_n,
   input  logic              load_cpu_n,
   input  logic              chip_en_n,
   input  logic              adv_n,
   input  logic              order_ilv,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] word_addr,
   output logic              burst_active
);

   localparam int unsigned CW = BEAT_BITS;
   localparam int unsigned UW = ADDR_W - CW;

   generate
      if (ADDR_W <= CW) begin : g_bad_width
         $error("burst_addr_gen: ADDR_W must exceed the beat field width");
      end
   endgenerate

   logic              load;
   logic [ADDR_W-1:0] addr_q;
   burst_order_e      order_q;
   logic [CW-1:0]     beat;
   logic [CW-1:0]     low_bits;

   burst_load_ctl u_load (
      .load_ctl_n (load_ctl_n),
      .load_cpu_n (load_cpu_n),
      .chip_en_n  (chip_en_n),
      .load       (load)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         order_q <= ORD_LINEAR;
      end else if (load) begin
         addr_q  <= addr_in;
         order_q <= burst_order_e'(order_ilv);
      end
   end

   burst_beat_ctr #(.CNT_W(CW)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .adv_n    (adv_n),
      .beat_q   (beat),
      .active_q (burst_active)
   );

   burst_order_map #(.CNT_W(CW), .SUPPORT_ILV(SUPPORT_ILV)) u_map (
      .start_bits (addr_q[CW-1:0]),
      .beat       (beat),
      .order      (order_q),
      .low_bits   (low_bits)
   );

   assign word_addr = {addr_q[ADDR_W-1:CW], low_bits};

   // R1: a controller load shows the sampled address next cycle
   a_r1_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
      !load_ctl_n |=> (word_addr == $past(addr_in)));

   // R3: a processor strobe without chip enable changes nothing
   a_r3_cpu_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (load_ctl_n && chip_en_n && adv_n) |=> $stable(word_addr));

   // R8: upper bits fixed between loads
   a_r8_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(word_addr[ADDR_W-1:CW]));

   // R9: both strobes together still give beat 0 of the new address
   a_r9_dual_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_ctl_n && !load_cpu_n && !chip_en_n) |=> (word_addr == $past(addr_in)));

   // R12: the burst flag never drops outside reset
   a_r12_active_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      burst_active |=> burst_active);

   logic [UW-1:0] unused_upper;
   assign unused_upper = addr_q[ADDR_W-1:CW];

endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;

   localparam int AW = 18;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          load_ctl_n = 1'b1;
   logic          load_cpu_n = 1'b1;
   logic          chip_en_n = 1'b1;
   logic          adv_n = 1'b1;
   logic          order_ilv = 1'b0;
   logic [AW-1:0] addr_in = '0;
   logic [AW-1:0] word_addr;
   logic          burst_active;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   string cur_req = "R11";

   // behavioural reference state
   logic [AW-1:0] m_start = '0;
   int            m_k = 0;
   logic          m_ilv = 1'b0;
   logic          m_act = 1'b0;

   always #10 clk = ~clk;

   burst_addr_gen #(.ADDR_W(AW)) i_burst_addr_gen (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_ctl_n   (load_ctl_n),
      .load_cpu_n   (load_cpu_n),
      .chip_en_n    (chip_en_n),
      .adv_n        (adv_n),
      .order_ilv    (order_ilv),
      .addr_in      (addr_in),
      .word_addr    (word_addr),
      .burst_active (burst_active)
   );

   function automatic logic [AW-1:0] model_addr();
      logic [1:0] kb;
      logic [1:0] lo;
      kb = m_k[1:0];
      lo = m_ilv ? (m_start[1:0] ^ kb) : (m_start[1:0] + kb);
      return {m_start[AW-1:2], lo};
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_start = '0; m_k = 0; m_ilv = 1'b0; m_act = 1'b0;
      end else if (!load_ctl_n || (!load_cpu_n && !chip_en_n)) begin
         m_start = addr_in; m_k = 0; m_ilv = order_ilv; m_act = 1'b1;
      end else if (m_act && !adv_n) begin
         m_k = (m_k + 1) % 4;
      end
   end

   task automatic chk(input string req, input logic [AW-1:0] exp_a, input logic exp_act);
      checks++;
      if (word_addr !== exp_a || burst_active !== exp_act) begin
         errors++;
         $display("FAIL %s: word_addr=%h active=%b expected word_addr=%h active=%b",
                  req, word_addr, burst_active, exp_a, exp_act);
      end
   endtask

   // compare against model at the falling edge, then apply the next inputs
   task automatic tick(input logic ctl, input logic cpu, input logic ce,
                       input logic adv, input logic ilv, input logic [AW-1:0] a);
      @(negedge clk);
      chk(cur_req, model_addr(), m_act);
      load_ctl_n = ctl; load_cpu_n = cpu; chip_en_n = ce;
      adv_n = adv; order_ilv = ilv; addr_in = a;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R11", '0, 1'b0);
      rst_n = 1'b1;

      // R11: advances before any load
      cur_req = "R11";
      tick(1, 1, 1, 0, 0, 18'h3FFFF);
      tick(1, 1, 1, 0, 0, 18'h3FFFF);
      tick(1, 1, 1, 0, 0, 18'h0);
      chk("R11", '0, 1'b0);

      // R1 R5 R7: controller load, interleaved, start 01
      cur_req = "R5";
      tick(0, 1, 1, 1, 1, 18'h12345);
      tick(1, 1, 1, 0, 0, 18'h0);
      chk("R1", 18'h12345, 1'b1);
      chk("R12", 18'h12345, 1'b1);
      tick(1, 1, 1, 0, 0, 18'h0);
      chk("R5", 18'h12344, 1'b1);
      tick(1, 1, 1, 0, 0, 18'h0);
      chk("R5", 18'h12347, 1'b1);
      tick(1, 1, 1, 0, 0, 18'h0);
      chk("R5", 18'h12346, 1'b1);
      tick(1, 1, 1, 1, 0, 18'h0);
      chk("R7", 18'h12345, 1'b1);

      // R4 hold, R3 gated processor strobe
      cur_req = "R3";
      tick(1, 0, 1, 1, 0, 18'h2AAAA);
      tick(1, 0, 1, 1, 0, 18'h15555);
      chk("R3", 18'h12345, 1'b1);
      tick(1, 1, 1, 1, 0, 18'h0);
      chk("R4", 18'h12345, 1'b1);

      // R6 R8 R7: linear, start 01 at the top of the space
      cur_req = "R6";
      tick(0, 1, 1, 0, 0, 18'h3FFFD);
      tick(1, 1, 1, 0, 1, 18'h0);
      chk("R9", 18'h3FFFD, 1'b1);
      tick(1, 1, 1, 0, 1, 18'h0);
      chk("R6", 18'h3FFFE, 1'b1);
      tick(1, 1, 1, 1, 1, 18'h0);
      chk("R10", 18'h3FFFF, 1'b1);
      tick(1, 1, 1, 0, 1, 18'h0);
      chk("R4", 18'h3FFFF, 1'b1);
      tick(1, 1, 1, 0, 0, 18'h0);
      chk("R8", 18'h3FFFC, 1'b1);
      tick(1, 1, 1, 1, 0, 18'h0);
      chk("R7", 18'h3FFFD, 1'b1);

      // R2: processor strobe with chip enable, interleaved start 10
      cur_req = "R2";
      tick(1, 0, 0, 1, 1, 18'h00AA2);
      tick(1, 1, 1, 0, 0, 18'h0);
      chk("R2", 18'h00AA2, 1'b1);
      tick(1, 1, 1, 0, 0, 18'h0);
      chk("R5", 18'h00AA3, 1'b1);

      // R9: both strobes plus advance, linear start 11
      cur_req = "R9";
      tick(0, 0, 0, 0, 0, 18'h0F0F3);
      tick(1, 1, 1, 0, 0, 18'h0);
      chk("R9", 18'h0F0F3, 1'b1);
      tick(1, 1, 1, 0, 0, 18'h0);
      chk("R6", 18'h0F0F0, 1'b1);

      // load while mid-burst restarts at beat 0
      cur_req = "R1";
      tick(0, 1, 1, 0, 1, 18'h00006);
      tick(1, 1, 1, 0, 1, 18'h0);
      chk("R1", 18'h00006, 1'b1);
      tick(1, 1, 1, 0, 1, 18'h0);
      chk("R5", 18'h00007, 1'b1);
      tick(1, 1, 1, 0, 1, 18'h0);
      chk("R5", 18'h00004, 1'b1);
      tick(1, 1, 1, 1, 1, 18'h0);
      chk("R5", 18'h00005, 1'b1);
      tick(1, 1, 1, 1, 1, 18'h0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000) begin
         errors++;
         $display("FAIL watchdog: cycles=%0d expected finish before 5000", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule